// File: doc/BRIEF.md
# Rotate-left unit with flags

This block is a purely combinational rotate-left datapath that produces condition codes. It takes a 32-bit operand and rotates its byte, word or longword portion left by one or two places, with each bit shifted out of the top re-entering at bit 0. It drives two results. The first is the bare rotated value, zero-extended, for a memory destination. The second is a register image in which only the selected low portion is replaced and the rest of the operand is kept.

The flag outputs carry the new carry, negative and zero values. Overflow is always forced low, and the half-carry input is passed straight through. Decode, operand fetch and write-back sequencing sit in the surrounding pipeline, which samples the outputs in the same cycle it presents the inputs.

Flag vectors on both `flags_i` and `flags_o` use the layout bit 4 = H, bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. The size codes on `size_i` are 00 = byte, 01 = word, 10 = longword and 11 = longword.

Top module: `rotl_flag_unit`

## Requirements
- R1: With size 00 (byte), `mem_o[7:0]` holds bits [7:0] rotated, `mem_o[31:8]` is zero, and `reg_o` equals `{src_i[31:8], mem_o[7:0]}`.
- R2: With size 01 (word), `mem_o[15:0]` holds bits [15:0] rotated, `mem_o[31:16]` is zero, and `reg_o` keeps `src_i[31:16]` (0xA5A5A5A5 rotated by two gives 0xA5A59696).
- R3: With size 10 (longword), all 32 bits rotate and `reg_o` equals `mem_o` (0xA5A5A5A5 gives 0x4B4B4B4B by one and 0x96969696 by two).
- R4: `count_two_i` = 0 rotates by one place and `count_two_i` = 1 rotates by two (word 0xA5A5 gives 0x4B4B and 0x9696 respectively).
- R5: Carry (`flags_o[0]`) is the last bit rotated out. That is the top bit of the selected size for a rotate by one, and the bit just below the top for a rotate by two.
- R6: Negative (`flags_o[3]`) equals the top bit of the result at the selected size.
- R7: Zero (`flags_o[2]`) is 1 exactly when every result bit at the selected size is 0.
- R8: Overflow (`flags_o[1]`) is 0 for every input, whatever `flags_i[1]` holds.
- R9: Half-carry (`flags_o[4]`) equals `flags_i[4]`. The incoming N, Z, V and C bits have no effect on any output.
- R10: Size code 11 produces exactly the same outputs as size code 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 32 | Operand, also the register value merged into `reg_o` |
| size_i | input | 2 | Operand size: 00 byte, 01 word, 10/11 longword |
| count_two_i | input | 1 | 0 rotates by one place, 1 rotates by two |
| flags_i | input | 5 | Previous flags {H,N,Z,V,C}; only H is used |
| reg_o | output | 32 | Register image with the rotated portion merged in |
| mem_o | output | 32 | Rotated result, zero-extended from the selected size |
| flags_o | output | 5 | New flags {H,N,Z,V,C} |

## Verification
The block holds no state, so any fault shows up on the ports in the same evaluation as the inputs that expose it, with no delay to account for. A wrong lane choice or a wrong merge mask appears as corrupted upper bits in `reg_o` or stray bits in `mem_o`. A wrong wrap order shows up as a carry that disagrees with the bit it should have captured. Directed A5/5A patterns and single-bit edge values at each size are mixed with seeded random operands so that the carry and zero cases are reached at every width and count.

// File: rtl/rotl_pkg.sv
package rotl_pkg;

  typedef enum logic [1:0] {
    RSZ_BYTE = 2'b00,
    RSZ_WORD = 2'b01,
    RSZ_LONG = 2'b10,
    RSZ_LALT = 2'b11
  } rot_size_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  localparam int NUM_LANES = 3;

  // lane index 0 = byte, 1 = word, 2 = long
  function automatic int lane_of(input logic [1:0] sz);
    case (sz)
      RSZ_BYTE: lane_of = 0;
      RSZ_WORD: lane_of = 1;
      default:  lane_of = 2;
    endcase
  endfunction

endpackage

// File: rtl/rotl_lane.sv
module rotl_lane #(
  parameter int W     = 8,
  parameter int OUT_W = 32
) (
  input  logic [W-1:0]     data_i,
  input  logic             two_i,
  output logic [OUT_W-1:0] rot_o,
  output logic             carry_o,
  output logic             neg_o,
  output logic             zero_o
);

  logic [W-1:0] step1;
  logic [W-1:0] step2;
  logic [W-1:0] res;

  always_comb begin
    step1   = {data_i[W-2:0], data_i[W-1]};
    step2   = {step1[W-2:0], step1[W-1]};
    res     = two_i ? step2 : step1;
    // last bit shifted out has just been wrapped into bit 0
    carry_o = res[0];
    neg_o   = res[W-1];
    zero_o  = ~|res;
    rot_o   = OUT_W'(res);
  end

endmodule

// File: rtl/rotl_pick.sv
module rotl_pick #(
  parameter int LONG_W = 32,
  parameter int LANES  = 3
) (
  input  logic [1:0]        size_i,
  input  logic [LONG_W-1:0] rot_i   [LANES],
  input  logic [LANES-1:0]  carry_i,
  input  logic [LANES-1:0]  neg_i,
  input  logic [LANES-1:0]  zero_i,
  output logic [LONG_W-1:0] res_o,
  output logic              carry_o,
  output logic              neg_o,
  output logic              zero_o
);
  import rotl_pkg::*;

  int sel;

  always_comb begin
    sel     = lane_of(size_i);
    res_o   = rot_i[sel];
    carry_o = carry_i[sel];
    neg_o   = neg_i[sel];
    zero_o  = zero_i[sel];
  end

endmodule

// File: rtl/rotl_merge.sv
module rotl_merge #(
  parameter int LONG_W = 32
) (
  input  logic [1:0]        size_i,
  input  logic [LONG_W-1:0] old_i,
  input  logic [LONG_W-1:0] res_i,
  output logic [LONG_W-1:0] reg_o
);
  import rotl_pkg::*;

  localparam int WORD_W = LONG_W / 2;
  localparam int BYTE_W = LONG_W / 4;
  localparam logic [LONG_W-1:0] KEEP_BYTE = {{(LONG_W-BYTE_W){1'b1}}, {BYTE_W{1'b0}}};
  localparam logic [LONG_W-1:0] KEEP_WORD = {{(LONG_W-WORD_W){1'b1}}, {WORD_W{1'b0}}};

  logic [LONG_W-1:0] keep;

  always_comb begin
    case (size_i)
      RSZ_BYTE: keep = KEEP_BYTE;
      RSZ_WORD: keep = KEEP_WORD;
      default:  keep = '0;
    endcase
    reg_o = (old_i & keep) | (res_i & ~keep);
  end

endmodule

// File: rtl/rotl_flag_unit.sv
module rotl_flag_unit #(
  parameter int LONG_W = 32
) (
  input  logic [LONG_W-1:0] src_i,
  input  logic [1:0]        size_i,
  input  logic              count_two_i,
  input  logic [4:0]        flags_i,
  output logic [LONG_W-1:0] reg_o,
  output logic [LONG_W-1:0] mem_o,
  output logic [4:0]        flags_o
);
  import rotl_pkg::*;

  logic [LONG_W-1:0]    lane_rot [NUM_LANES];
  logic [NUM_LANES-1:0] lane_c;
  logic [NUM_LANES-1:0] lane_n;
  logic [NUM_LANES-1:0] lane_z;
  logic                 sel_c;
  logic                 sel_n;
  logic                 sel_z;
  ccr_t                 prev;
  ccr_t                 next;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = LONG_W >> (NUM_LANES - 1 - g);
    rotl_lane #(.W(LW), .OUT_W(LONG_W)) u_lane (
      .data_i  (src_i[LW-1:0]),
      .two_i   (count_two_i),
      .rot_o   (lane_rot[g]),
      .carry_o (lane_c[g]),
      .neg_o   (lane_n[g]),
      .zero_o  (lane_z[g])
    );
  end

  rotl_pick #(.LONG_W(LONG_W), .LANES(NUM_LANES)) u_pick (
    .size_i  (size_i),
    .rot_i   (lane_rot),
    .carry_i (lane_c),
    .neg_i   (lane_n),
    .zero_i  (lane_z),
    .res_o   (mem_o),
    .carry_o (sel_c),
    .neg_o   (sel_n),
    .zero_o  (sel_z)
  );

  rotl_merge #(.LONG_W(LONG_W)) u_merge (
    .size_i (size_i),
    .old_i  (src_i),
    .res_i  (mem_o),
    .reg_o  (reg_o)
  );

  always_comb begin
    prev   = ccr_t'(flags_i);
    next.h = prev.h;
    next.n = sel_n;
    next.z = sel_z;
    next.v = 1'b0;
    next.c = sel_c;
    flags_o = next;
  end

endmodule

// File: rtl/rotl_flag_unit_chk.sv
module rotl_flag_unit_chk #(
  parameter int LONG_W = 32
) (
  input logic [LONG_W-1:0] src_i,
  input logic [1:0]        size_i,
  input logic              count_two_i,
  input logic [4:0]        flags_i,
  input logic [LONG_W-1:0] reg_o,
  input logic [LONG_W-1:0] mem_o,
  input logic [4:0]        flags_o
);

  int top;

  always_comb begin
    case (size_i)
      2'b00:   top = LONG_W / 4 - 1;
      2'b01:   top = LONG_W / 2 - 1;
      default: top = LONG_W - 1;
    endcase
    AST_NO_OVERFLOW: assert (flags_o[1] == 1'b0) else $error("overflow set"); // R8
    AST_HALF_PASS: assert (flags_o[4] == flags_i[4]) else $error("H not passed"); // R9
    AST_CARRY_SRC: assert (flags_o[0] == src_i[count_two_i ? top - 1 : top]) else $error("carry bit"); // R5
    AST_ZERO_MATCH: assert (flags_o[2] == (mem_o == '0)) else $error("zero flag"); // R7
    AST_NEG_TOP: assert (flags_o[3] == mem_o[top]) else $error("neg flag"); // R6
    AST_UPPER_KEEP: assert ((size_i[1] == 1'b1) || ((reg_o >> (top + 1)) == (src_i >> (top + 1)))) else $error("upper bits"); // R2
    AST_LONG_SAME: assert ((size_i[1] == 1'b0) || (reg_o == mem_o)) else $error("long merge"); // R3
  end

endmodule

bind rotl_flag_unit rotl_flag_unit_chk #(.LONG_W(LONG_W)) u_chk (
  .src_i       (src_i),
  .size_i      (size_i),
  .count_two_i (count_two_i),
  .flags_i     (flags_i),
  .reg_o       (reg_o),
  .mem_o       (mem_o),
  .flags_o     (flags_o)
);

// File: tb/tb_rotl_flag_unit.sv
module tb_rotl_flag_unit;

  localparam real HALF = 2.5;

  logic        clk;
  logic        rst_n;
  logic [31:0] src;
  logic [1:0]  size;
  logic        two;
  logic [4:0]  fin;
  logic [31:0] reg_o;
  logic [31:0] mem_o;
  logic [4:0]  flags_o;

  int checks;
  int errors;
  bit done;

  rotl_flag_unit dut (
    .src_i       (src),
    .size_i      (size),
    .count_two_i (two),
    .flags_i     (fin),
    .reg_o       (reg_o),
    .mem_o       (mem_o),
    .flags_o     (flags_o)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  function automatic int width_of(input logic [1:0] sz);
    if (sz == 2'b00) return 8;
    if (sz == 2'b01) return 16;
    return 32;
  endfunction

  function automatic logic [31:0] mask_of(input int w);
    return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model: rotate one bit at a time
  task automatic run(input logic [31:0] s, input logic [1:0] sz, input logic t,
                     input logic [4:0] f, input string rres);
    int w;
    logic [31:0] m, v, ex_reg;
    logic cy;
    w = width_of(sz);
    m = mask_of(w);
    v = s & m;
    cy = 1'b0;
    for (int k = 0; k < (t ? 2 : 1); k++) begin
      cy = v[w-1];
      v = ((v << 1) | {31'b0, cy}) & m;
    end
    ex_reg = (s & ~m) | v;
    @(posedge clk);
    src <= s; size <= sz; two <= t; fin <= f;
    @(negedge clk);
    chk(rres, "mem_o", mem_o, v);
    chk(rres, "reg_o", reg_o, ex_reg);
    chk("R5", "carry", {31'b0, flags_o[0]}, {31'b0, cy});
    chk("R6", "neg", {31'b0, flags_o[3]}, {31'b0, v[w-1]});
    chk("R7", "zero", {31'b0, flags_o[2]}, {31'b0, v == 32'b0});
    chk("R8", "ovf", {31'b0, flags_o[1]}, 32'b0);
    chk("R9", "half", {31'b0, flags_o[4]}, {31'b0, f[4]});
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r_a, r_b;
    logic [4:0]  f_a;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0;
    src = '0; size = 2'b10; two = 1'b0; fin = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", "reset mem_o", mem_o, 32'b0);
    chk("R7", "reset flags", {27'b0, flags_o}, 32'h4);
    rst_n = 1'b1;

    // directed corner cases
    run(32'h0000_A5A5, 2'b01, 1'b0, 5'b0, "R4");
    chk("R4", "word by one", mem_o, 32'h0000_4B4B);
    chk("R5", "word by one C", {31'b0, flags_o[0]}, 32'h1);
    run(32'hA5A5_A5A5, 2'b01, 1'b1, 5'b0, "R2");
    chk("R2", "word keeps upper", reg_o, 32'hA5A5_9696);
    chk("R6", "word by two N", {31'b0, flags_o[3]}, 32'h1);
    run(32'hA5A5_A5A5, 2'b10, 1'b0, 5'b0, "R3");
    chk("R3", "long by one", reg_o, 32'h4B4B_4B4B);
    run(32'hA5A5_A5A5, 2'b10, 1'b1, 5'b0, "R3");
    chk("R3", "long by two", mem_o, 32'h9696_9696);
    run(32'h1234_5680, 2'b00, 1'b0, 5'b0, "R1");
    chk("R1", "byte 80 by one", reg_o, 32'h1234_5601);
    run(32'hFFFF_FF40, 2'b00, 1'b1, 5'b0, "R1");
    chk("R5", "byte 40 by two C", {31'b0, flags_o[0]}, 32'h1);
    run(32'h0000_0080, 2'b00, 1'b1, 5'b0, "R1");
    chk("R5", "byte 80 by two C", {31'b0, flags_o[0]}, 32'h0);
    run(32'hFFFF_0000, 2'b01, 1'b1, 5'b11111, "R2");
    chk("R7", "word zero", {31'b0, flags_o[2]}, 32'h1);
    chk("R8", "V in ignored", {31'b0, flags_o[1]}, 32'h0);
    run(32'h0000_0001, 2'b10, 1'b0, 5'b01111, "R9");
    chk("R9", "stale NZVC ignored", {27'b0, flags_o}, 32'h0);

    // size code 11 against 10
    for (int i = 0; i < 20; i++) begin
      r_a = $urandom;
      run(r_a, 2'b11, i[0], 5'b0, "R10");
      r_b = reg_o;
      f_a = flags_o;
      run(r_a, 2'b10, i[0], 5'b0, "R3");
      chk("R10", "alt size reg", r_b, reg_o);
      chk("R10", "alt size flags", {27'b0, f_a}, {27'b0, flags_o});
    end

    // seeded random
    void'($urandom(32'd7391));
    for (int i = 0; i < 600; i++) begin
      logic [1:0] sz;
      logic [31:0] s;
      sz = 2'($urandom_range(0, 3));
      s = $urandom;
      if ((i % 17) == 0) s = s & 32'hFFFF_0000;
      run(s, sz, 1'($urandom), 5'($urandom),
          (sz == 2'b00) ? "R1" : (sz == 2'b01) ? "R2" : "R3");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule